// File: doc/BRIEF.md
# Power Domain State Request Controller

This block takes requests for a new power state across four power domains. It checks each request, sequences it, and reports the result in one status word. A request comes either from a software write to the status word or from a hardware request port. The state field has one bit per domain: a 1 means the domain is off and a 0 means it is on.

A request that tries to switch some domains on and others off at once is unsafe. So is a request that would leave the switched core domain on while the execute-in-place (XIP) memory domain is off. The block does not reject either kind. It records the request, raises the error flag for the source that sent it, and carries out only the power-up part. This keeps the chip from getting stuck in a state it cannot leave.

Switching the core domain off waits until the processors report that they have halted. While the request waits, software may replace it or cancel it. An accepted transition is passed to an external power sequencer through a request/done handshake. Register writes are locked out until the sequencer reports done.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the status word reads 0x000F: bits 3:0 hold the current state and read all ones, bits 7:4 hold the requested state and read zero, all flags read zero, and `seq_req` is low.
- R2: A write with bit 15 set issues a request; bits 7:4 of the write carry it. One cycle later bits 7:4 hold the request and the waiting flag (bit 12) is set. A write with bit 15 clear issues no request.
- R3: A pending request whose applied target differs from the current state moves on after one waiting cycle. Waiting clears, changing (bit 13) sets, and `seq_req` rises with `seq_state` equal to the target. One cycle after `seq_done` is sampled high, the current state equals the target and changing clears.
- R4: A request whose applied target equals the current state returns to idle after its single waiting cycle, without raising `seq_req`.
- R5: A request is invalid if it mixes turning domains on (state bit 1 to 0) with turning domains off (0 to 1). It is also invalid if it asks for bit 3 (switched core) = 0 together with bit 2 (XIP) = 1. An invalid request is still stored in bits 7:4 and sets bit 10 (software source) or bit 11 (hardware source). Its target is the current state with only the power-up bits applied. If bit 3 of that target is 0, bit 2 is forced to 0.
- R6: A target that turns bit 3 from 0 to 1 stays in waiting until `cpu_halted` is sampled high.
- R7: While a software request is waiting, a new software request replaces it. A replacement equal to the current state cancels it.
- R8: While changing is set, every register write is ignored: the request, the flags and the write-one-to-clear (W1C) bits are all left as they were.
- R9: A software request is dropped and sets request-ignored (bit 8) in two cases: it arrives in the same cycle as a hardware request while idle (the hardware request is taken), or it arrives while a hardware request is pending.
- R10: A hardware request that arrives while a request is waiting or changing is dropped and sets bit 9 (rejected while busy).
- R11: Writing 1 to bit 8 or bit 9 clears that flag. If the same cycle also sets the flag, the set wins.
- R12: A valid request clears the error flag of its own source only. It does not clear the other source's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 16 | Write data: bit 15 issues a request, bits 7:4 carry the request, bits 9:8 are W1C |
| rd_data | output | 16 | Status word |
| hw_req_valid | input | 1 | Hardware request strobe |
| hw_req_state | input | 4 | Hardware requested state |
| cpu_halted | input | 1 | Processors halted |
| seq_req | output | 1 | Transition request to the sequencer |
| seq_state | output | 4 | Target state for the sequencer |
| seq_done | input | 1 | Sequencer finished the transition |

## Verification
A software write and a hardware request can land on the same clock edge. The bench provokes this from the idle state with both strobes driven in one cycle, and again while a hardware request is pending. It checks that the hardware request wins and that request-ignored is set. One of these collisions has the write also carry a W1C for request-ignored; the flag must still come out set. A behavioural reference model predicts the status word, `seq_req` and `seq_state` on every clock. Hand-computed values are checked at the key steps.

// File: rtl/pwr_state_pkg.sv
// Shared types for the power domain state request controller.
// Assumes: every module includes this package before use.
package pwr_state_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WAIT   = 2'd1,
        PH_CHANGE = 2'd2
    } phase_t;

    typedef enum logic {
        SRC_SW = 1'b0,
        SRC_HW = 1'b1
    } src_t;
endpackage

// File: rtl/pwr_req_check.sv
// Combinational check of a requested state against the current state.
// Flags mixed power-up/power-down changes and a core-on/XIP-off result.
// For an invalid request it builds a safe target: power-up bits only, and
// XIP forced on whenever the core ends up on.
// Assumes: the current state is itself a legal combination.
module pwr_req_check #(
    parameter int NUM_DOM  = 4,
    parameter int CORE_BIT = 3,
    parameter int XIP_BIT  = 2
) (
    input  logic [NUM_DOM-1:0] cur_state,
    input  logic [NUM_DOM-1:0] req_state,
    output logic               invalid,
    output logic [NUM_DOM-1:0] target
);
    logic [NUM_DOM-1:0] up_bits;
    logic [NUM_DOM-1:0] dn_bits;
    logic [NUM_DOM-1:0] safe;

    // Per-domain change direction: 1->0 powers up, 0->1 powers down.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dir
        assign up_bits[d] =  cur_state[d] & ~req_state[d];
        assign dn_bits[d] = ~cur_state[d] &  req_state[d];
    end

    // Validity and applied target selection.
    always_comb begin
        invalid = ((|up_bits) && (|dn_bits)) ||
                  (!req_state[CORE_BIT] && req_state[XIP_BIT]);
        safe = cur_state & ~up_bits;
        if (!safe[CORE_BIT]) begin
            safe[XIP_BIT] = 1'b0;
        end
        target = invalid ? safe : req_state;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Phase sequencer: idle, waiting for evaluation or for the processors to
// halt, and changing while the external sequencer works. Holds the current,
// requested and target states and the source of the pending request.
// Assumes: accept is only raised in the idle or waiting phase.
module pwr_seq_fsm
    import pwr_state_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int CORE_BIT = 3,
    parameter int XIP_BIT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  src_t               src_in,
    input  logic [NUM_DOM-1:0] new_req,
    input  logic [NUM_DOM-1:0] new_target,
    input  logic               cpu_halted,
    input  logic               seq_done,
    output phase_t             phase,
    output src_t               pend_src,
    output logic [NUM_DOM-1:0] cur_q,
    output logic [NUM_DOM-1:0] req_q,
    output logic [NUM_DOM-1:0] tgt_q
);
    logic core_down;

    // Target turns the switched core domain off.
    assign core_down = tgt_q[CORE_BIT] & ~cur_q[CORE_BIT];

    // Phase progression and state capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            pend_src <= SRC_SW;
            cur_q    <= '1;
            req_q    <= '0;
            tgt_q    <= '1;
        end else if (accept) begin
            req_q    <= new_req;
            tgt_q    <= new_target;
            pend_src <= src_in;
            phase    <= PH_WAIT;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (tgt_q == cur_q) begin
                        phase <= PH_IDLE;
                    end else if (!core_down || cpu_halted) begin
                        phase <= PH_CHANGE;
                    end
                end
                PH_CHANGE: begin
                    if (seq_done) begin
                        cur_q <= tgt_q;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_HALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && core_down && !cpu_halted && !accept) |=> (phase != PH_CHANGE)); // R6

    AST_CUR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> ($past(seq_done) && $past(phase) == PH_CHANGE)); // R3

    AST_SAFE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHANGE) |-> !(!tgt_q[CORE_BIT] && tgt_q[XIP_BIT])); // R5
endmodule

// File: rtl/pwr_status_flags.sv
// Sticky status flags: request-ignored and busy-reject (W1C, set wins),
// and per-source error flags refreshed on every accepted request.
// Assumes: sw_wr is already masked off during a transition.
module pwr_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic clr_ign,
    input  logic clr_busy,
    input  logic set_ign,
    input  logic set_busy,
    input  logic acc_sw,
    input  logic acc_hw,
    input  logic chk_bad,
    output logic ign_q,
    output logic busy_q,
    output logic bad_sw_q,
    output logic bad_hw_q
);
    // W1C flags with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ign_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (set_ign)                 ign_q  <= 1'b1;
            else if (sw_wr && clr_ign)   ign_q  <= 1'b0;
            if (set_busy)                busy_q <= 1'b1;
            else if (sw_wr && clr_busy)  busy_q <= 1'b0;
        end
    end

    // Per-source error flags follow that source's latest accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_sw_q <= 1'b0;
            bad_hw_q <= 1'b0;
        end else begin
            if (acc_sw) bad_sw_q <= chk_bad;
            if (acc_hw) bad_hw_q <= chk_bad;
        end
    end

    AST_IGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ign_q) |-> $past(set_ign)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_busy |=> busy_q); // R11
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the power domain state request controller. Arbitrates software
// writes against hardware requests, checks the chosen request, and drives
// the phase sequencer and the status flags. Assembles the status word.
// Assumes: seq_done is only raised while seq_req is high.
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int CORE_BIT = 3,
    parameter int XIP_BIT  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2*NUM_DOM+7:0]   wr_data,
    output logic [2*NUM_DOM+7:0]   rd_data,
    input  logic                   hw_req_valid,
    input  logic [NUM_DOM-1:0]     hw_req_state,
    input  logic                   cpu_halted,
    output logic                   seq_req,
    output logic [NUM_DOM-1:0]     seq_state,
    input  logic                   seq_done
);
    localparam int STW      = 2*NUM_DOM + 8;
    localparam int REQ_LSB  = NUM_DOM;
    localparam int FLAG_LSB = 2*NUM_DOM;
    localparam int GO_BIT   = STW - 1;

    phase_t             phase;
    src_t               pend_src;
    logic [NUM_DOM-1:0] cur_q, req_q, tgt_q;
    logic [NUM_DOM-1:0] new_req, chk_target;
    logic               chk_bad;
    logic               sw_wr, sw_go;
    logic               acc_sw, acc_hw, accept, set_ign, set_busy;
    logic               ign_q, busy_q, bad_sw_q, bad_hw_q;

    // Writes are locked out during a transition.
    assign sw_wr = wr_en && (phase != PH_CHANGE);
    assign sw_go = sw_wr && wr_data[GO_BIT];

    // Source arbitration per phase.
    always_comb begin
        acc_sw   = 1'b0;
        acc_hw   = 1'b0;
        set_ign  = 1'b0;
        set_busy = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (hw_req_valid) begin
                    acc_hw  = 1'b1;
                    set_ign = sw_go;
                end else begin
                    acc_sw  = sw_go;
                end
            end
            PH_WAIT: begin
                set_busy = hw_req_valid;
                if (sw_go) begin
                    if (pend_src == SRC_SW) acc_sw  = 1'b1;
                    else                    set_ign = 1'b1;
                end
            end
            default: set_busy = hw_req_valid;
        endcase
    end

    assign accept  = acc_sw | acc_hw;
    assign new_req = acc_hw ? hw_req_state : wr_data[REQ_LSB +: NUM_DOM];

    pwr_req_check #(
        .NUM_DOM (NUM_DOM),
        .CORE_BIT(CORE_BIT),
        .XIP_BIT (XIP_BIT)
    ) u_check (
        .cur_state(cur_q),
        .req_state(new_req),
        .invalid  (chk_bad),
        .target   (chk_target)
    );

    pwr_seq_fsm #(
        .NUM_DOM (NUM_DOM),
        .CORE_BIT(CORE_BIT),
        .XIP_BIT (XIP_BIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .src_in    (acc_hw ? SRC_HW : SRC_SW),
        .new_req   (new_req),
        .new_target(chk_target),
        .cpu_halted(cpu_halted),
        .seq_done  (seq_done),
        .phase     (phase),
        .pend_src  (pend_src),
        .cur_q     (cur_q),
        .req_q     (req_q),
        .tgt_q     (tgt_q)
    );

    pwr_status_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_wr   (sw_wr),
        .clr_ign (wr_data[FLAG_LSB]),
        .clr_busy(wr_data[FLAG_LSB+1]),
        .set_ign (set_ign),
        .set_busy(set_busy),
        .acc_sw  (acc_sw),
        .acc_hw  (acc_hw),
        .chk_bad (chk_bad),
        .ign_q   (ign_q),
        .busy_q  (busy_q),
        .bad_sw_q(bad_sw_q),
        .bad_hw_q(bad_hw_q)
    );

    // Status word and sequencer handshake.
    assign rd_data   = {2'b00, (phase == PH_CHANGE), (phase == PH_WAIT),
                        bad_hw_q, bad_sw_q, busy_q, ign_q, req_q, cur_q};
    assign seq_req   = (phase == PH_CHANGE);
    assign seq_state = tgt_q;

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_state))); // R3

    AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHANGE) |=> $stable(req_q)); // R8
endmodule

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        hw_req_valid = 1'b0;
    logic [3:0]  hw_req_state = '0;
    logic        cpu_halted = 1'b0;
    logic        seq_req;
    logic [3:0]  seq_state;
    logic        seq_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pwr_state_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .hw_req_valid(hw_req_valid),
        .hw_req_state(hw_req_state), .cpu_halted(cpu_halted),
        .seq_req(seq_req), .seq_state(seq_state), .seq_done(seq_done)
    );

    // Behavioural reference model: phase 0 idle, 1 waiting, 2 changing.
    int m_ph, m_cur, m_req, m_tgt, m_src;
    int m_ign, m_busy, m_bsw, m_bhw;

    function automatic int fix_target(int cur, int r, output int bad);
        int up, dn, t;
        up  = cur & ~r & 15;
        dn  = ~cur & r & 15;
        bad = ((up != 0 && dn != 0) || (((r >> 3) & 1) == 0 && ((r >> 2) & 1) == 1)) ? 1 : 0;
        if (bad == 0) return r;
        t = cur & ~up & 15;
        if (((t >> 3) & 1) == 0) t = t & ~4;
        return t;
    endfunction

    always @(posedge clk) begin
        int go, wr, asw, ahw, sign, sbusy, r, t, bad, n_ph;
        if (!rst_n) begin
            m_ph = 0; m_cur = 15; m_req = 0; m_tgt = 15; m_src = 0;
            m_ign = 0; m_busy = 0; m_bsw = 0; m_bhw = 0;
        end else begin
            wr = (wr_en && m_ph != 2) ? 1 : 0;
            go = (wr == 1 && wr_data[15]) ? 1 : 0;
            asw = 0; ahw = 0; sign = 0; sbusy = 0;
            if (m_ph == 0) begin
                if (hw_req_valid) begin ahw = 1; sign = go; end
                else asw = go;
            end else if (m_ph == 1) begin
                sbusy = hw_req_valid;
                if (go == 1) begin
                    if (m_src == 0) asw = 1; else sign = 1;
                end
            end else begin
                sbusy = hw_req_valid;
            end
            r = (ahw == 1) ? int'(hw_req_state) : int'(wr_data[7:4]);
            t = fix_target(m_cur, r, bad);
            if (sign == 1) m_ign = 1; else if (wr == 1 && wr_data[8]) m_ign = 0;
            if (sbusy == 1) m_busy = 1; else if (wr == 1 && wr_data[9]) m_busy = 0;
            if (asw == 1) m_bsw = bad;
            if (ahw == 1) m_bhw = bad;
            n_ph = m_ph;
            if (asw == 1 || ahw == 1) begin
                m_req = r; m_tgt = t; m_src = ahw; n_ph = 1;
            end else if (m_ph == 1) begin
                if (m_tgt == m_cur) n_ph = 0;
                else if (!(((m_tgt >> 3) & 1) == 1 && ((m_cur >> 3) & 1) == 0) || cpu_halted) n_ph = 2;
            end else if (m_ph == 2 && seq_done) begin
                m_cur = m_tgt; n_ph = 0;
            end
            m_ph = n_ph;
        end
    end

    function automatic logic [15:0] model_word();
        return 16'((((m_ph == 2) ? 1 : 0) << 13) | (((m_ph == 1) ? 1 : 0) << 12) |
                   (m_bhw << 11) | (m_bsw << 10) | (m_busy << 9) | (m_ign << 8) |
                   (m_req << 4) | m_cur);
    endfunction

    // Cycle-by-cycle comparison against the model (R2 R3 R6 R8 R10).
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_data !== model_word() || seq_req !== (m_ph == 2) ||
                seq_state !== 4'(m_tgt)) begin
                errors++;
                $display("FAIL model R3: status %h seq %b/%h expected %h %b/%h",
                         rd_data, seq_req, seq_state, model_word(), (m_ph == 2), 4'(m_tgt));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: status %h expected %h", tag, rd_data, exp);
        end
    endtask

    task automatic chk_seq(input string tag, input logic er, input logic [3:0] es);
        checks++;
        if (seq_req !== er || (er && seq_state !== es)) begin
            errors++;
            $display("FAIL %s: seq %b/%h expected %b/%h", tag, seq_req, seq_state, er, es);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sw(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic hw(input logic [3:0] s);
        hw_req_valid = 1'b1; hw_req_state = s;
        step();
        hw_req_valid = 1'b0; hw_req_state = '0;
    endtask

    task automatic both(input logic [15:0] d, input logic [3:0] s);
        wr_en = 1'b1; wr_data = d; hw_req_valid = 1'b1; hw_req_state = s;
        step();
        wr_en = 1'b0; wr_data = '0; hw_req_valid = 1'b0; hw_req_state = '0;
    endtask

    task automatic done_pulse();
        seq_done = 1'b1;
        step();
        seq_done = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        chk("R1 reset", 16'h000F); chk_seq("R1 reset", 1'b0, 4'h0);
        // Power everything up.
        sw(16'h8000); chk("R2 request", 16'h100F);
        step(); chk("R3 changing", 16'h200F); chk_seq("R3 handshake", 1'b1, 4'h0);
        done_pulse(); chk("R3 done", 16'h0000);
        // Request equal to current state.
        sw(16'h8000); chk("R4 wait", 16'h1000);
        step(); chk("R4 idle", 16'h0000); chk_seq("R4 no seq", 1'b0, 4'h0);
        // Core off needs the halt.
        sw(16'h8080); chk("R6 wait", 16'h1080);
        step(); chk("R6 hold", 16'h1080);
        step(); chk("R6 hold", 16'h1080); chk_seq("R6 no seq", 1'b0, 4'h0);
        cpu_halted = 1'b1;
        step(); chk("R6 go", 16'h2080); chk_seq("R6 seq", 1'b1, 4'h8);
        cpu_halted = 1'b0;
        done_pulse(); chk("R6 done", 16'h0088);
        // Back on, then cancel a waiting core-off.
        sw(16'h8000); step(); done_pulse(); chk("R3 up", 16'h0000);
        sw(16'h8080); chk("R7 wait", 16'h1080);
        step(); chk("R7 hold", 16'h1080);
        sw(16'h8000); chk("R7 rewrite", 16'h1000);
        step(); chk("R7 cancelled", 16'h0000);
        // Mixed request.
        sw(16'h8010); step(); done_pulse(); chk("R3 bank off", 16'h0011);
        sw(16'h8020); chk("R5 mixed", 16'h1421);
        step(); chk("R5 mixed change", 16'h2421); chk_seq("R5 up only", 1'b1, 4'h0);
        done_pulse(); chk("R5 mixed done", 16'h0420);
        // Valid clears the sw error; core on with XIP off forces XIP on.
        cpu_halted = 1'b1;
        sw(16'h80C0); chk("R12 sw clears", 16'h10C0);
        step(); done_pulse(); chk("R3 core xip off", 16'h00CC);
        sw(16'h8040); chk("R5 xip rule", 16'h144C);
        step(); chk_seq("R5 xip forced", 1'b1, 4'h0);
        done_pulse(); chk("R5 xip done", 16'h0440);
        cpu_halted = 1'b0;
        // Hardware source does not clear the sw error.
        hw(4'h0); chk("R12 hw keeps sw", 16'h1400);
        step(); chk("R12 idle", 16'h0400);
        sw(16'h8000); step(); chk("R12 sw cleared", 16'h0000);
        hw(4'h4); chk("R5 hw bad", 16'h1840);
        step(); chk("R5 hw idle", 16'h0840);
        // Same-cycle collision in idle.
        both(16'h8010, 4'h0); chk("R9 collision", 16'h1100);
        step(); chk("R9 idle", 16'h0100);
        sw(16'h0100); chk("R11 clear", 16'h0000);
        // Hardware pending: sw dropped, hw dropped.
        hw(4'h8); chk("R2 hw wait", 16'h1080);
        sw(16'h8000); chk("R9 sw vs hw pending", 16'h1180);
        hw(4'h0); chk("R10 busy", 16'h1380);
        cpu_halted = 1'b1;
        step(); chk("R6 go", 16'h2380); chk_seq("R3 seq", 1'b1, 4'h8);
        cpu_halted = 1'b0;
        sw(16'h8300); chk("R8 locked", 16'h2380);
        hw(4'h0); chk("R10 busy change", 16'h2380);
        done_pulse(); chk("R3 done", 16'h0388);
        both(16'h8300, 4'h8); chk("R11 set wins", 16'h1188);
        step(); chk("R11 idle", 16'h0188);
        sw(16'h0100); chk("R11 clear ign", 16'h0088);
        repeat (3) step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule